// File: doc/BRIEF.md
# Register Busy-Bit Issue Interlock

This block decides, one cycle at a time, whether the decoded instruction at the head of a single-issue pipeline may start. It keeps one busy flag per architectural register. When an operation of a long-latency class (load, store, multiply, divide, floating point) is granted, its tracked register is flagged busy. The flag stays set until a functional unit reports completion for that register. An instruction that names a flagged register, as a source or as its destination, is held until the flag drops. Because ordering rests only on these flags, the interlock works the same whatever each unit's latency is.

Single-cycle integer and logic operations never touch the flags. For a store, the flagged register is the one that supplies the store data, which is the second source field. Completion reports arrive on several parallel ports. A report clears its register's flag in the cycle it arrives, so a waiting instruction is granted in that same cycle. Register 0 is hardwired and is never flagged.

Top module: `sb_interlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every busy flag reads 0. With no valid instruction, both issue_grant and issue_stall are 0.
- R2: issue_grant is 1 only while in_valid is 1, and issue_grant and issue_stall are never both 1. An instruction presented with in_valid at 0 changes no busy flag.
- R3: Class codes 1 (load), 3 (multiply), 4 (divide) and 5 (floating point) are long-latency. Granting one with in_dst_used at 1 sets the flag of in_dst, and busy_vec shows it on the next cycle.
- R4: Granting class 2 (store) sets the flag of in_src_b, the store-data register. The destination field is ignored.
- R5: Class codes 0, 6 and 7 are single-cycle. Granting one changes no busy flag.
- R6: A valid instruction whose used source register is flagged gets issue_stall at 1 and issue_grant at 0. The stalled instruction changes no flag.
- R7: A valid non-store instruction whose used destination is already flagged is stalled.
- R8: A completion report (cpl_valid[p] with index cpl_idx[p*5 +: 5] at the default size) lets an instruction waiting on that register be granted in the same cycle. The flag is clear on the next cycle unless a grant in that cycle sets it again, in which case it stays set.
- R9: The flag of register 0 is never set. Naming register 0 as a source or destination never causes a stall.
- R10: A set flag stays set, however many cycles pass, until a completion names its register.
- R11: Completions on several ports in one cycle clear every named flag. A completion that names a register that is not flagged has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 3 | Operation class code |
| in_src_a | input | IDX_W | First source register index |
| in_src_a_used | input | 1 | First source is read |
| in_src_b | input | IDX_W | Second source index (store data for stores) |
| in_src_b_used | input | 1 | Second source is read |
| in_dst | input | IDX_W | Destination register index |
| in_dst_used | input | 1 | Destination is written |
| cpl_valid | input | NUM_CPL | Per-port completion strobe |
| cpl_idx | input | NUM_CPL*IDX_W | Per-port completed register index |
| issue_grant | output | 1 | Instruction starts this cycle |
| issue_stall | output | 1 | Instruction is held this cycle |
| busy_vec | output | NUM_REGS | Busy flag per register |

## Verification
A flag that is wrongly set shows up as a stall on the very next instruction that names the register, or as a set bit in busy_vec one cycle after the faulty grant. A flag that is wrongly cleared lets a dependent instruction be granted in the same cycle, and a wrong same-cycle clear path shows up as a missed or spurious grant in the completion cycle itself. The directed scenarios hold a dependent instruction across several idle cycles, release it by completion, and combine a clear and a fresh set on one register. Each divergence therefore appears at the ports within one cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [2:0] {
      CLS_ALU   = 3'd0,
      CLS_LOAD  = 3'd1,
      CLS_STORE = 3'd2,
      CLS_MUL   = 3'd3,
      CLS_DIV   = 3'd4,
      CLS_FP    = 3'd5,
      CLS_RSV6  = 3'd6,
      CLS_RSV7  = 3'd7
   } op_class_e;

   localparam int CLASS_W = 3;

   // Classes whose result arrives after an unknown number of cycles.
   function automatic logic is_long_class(input logic [CLASS_W-1:0] cls);
      case (op_class_e'(cls))
         CLS_LOAD, CLS_STORE, CLS_MUL, CLS_DIV, CLS_FP: is_long_class = 1'b1;
         default:                                       is_long_class = 1'b0;
      endcase
   endfunction

   function automatic logic is_store_class(input logic [CLASS_W-1:0] cls);
      is_store_class = (op_class_e'(cls) == CLS_STORE);
   endfunction

endpackage

// File: rtl/sb_cpl_decode.sv
module sb_cpl_decode #(
   parameter int NUM_REGS = 32,
   parameter int NUM_CPL  = 2,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_CPL-1:0]       cpl_valid,
   input  logic [NUM_CPL*IDX_W-1:0] cpl_idx,
   output logic [NUM_REGS-1:0]      clr_mask
);

   logic [NUM_REGS-1:0] port_mask [NUM_CPL];

   for (genvar p = 0; p < NUM_CPL; p++) begin : g_port
      always_comb begin
         port_mask[p] = '0;
         if (cpl_valid[p]) port_mask[p][cpl_idx[p*IDX_W +: IDX_W]] = 1'b1;
      end
   end

   always_comb begin
      clr_mask = '0;
      for (int k = 0; k < NUM_CPL; k++) clr_mask = clr_mask | port_mask[k];
   end

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
   parameter int NUM_REGS = 32,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0] eff_busy,
   input  logic                in_valid,
   input  logic [IDX_W-1:0]    src_a,
   input  logic                src_a_used,
   input  logic [IDX_W-1:0]    src_b,
   input  logic                src_b_used,
   input  logic [IDX_W-1:0]    dst,
   input  logic                dst_check,
   output logic                grant,
   output logic                stall
);

   logic hit_a, hit_b, hit_d, conflict;

   always_comb begin
      hit_a    = src_a_used & eff_busy[src_a];
      hit_b    = src_b_used & eff_busy[src_b];
      hit_d    = dst_check  & eff_busy[dst];
      conflict = hit_a | hit_b | hit_d;
      grant    = in_valid & ~conflict;
      stall    = in_valid &  conflict;
   end

endmodule

// File: rtl/sb_mark_select.sv
module sb_mark_select #(
   parameter int NUM_REGS     = 32,
   parameter bit R0_HARDWIRED = 1'b1,
   localparam int IDX_W       = $clog2(NUM_REGS)
) (
   input  logic                       grant,
   input  logic [sb_pkg::CLASS_W-1:0] cls,
   input  logic [IDX_W-1:0]           src_b,
   input  logic                       src_b_used,
   input  logic [IDX_W-1:0]           dst,
   input  logic                       dst_used,
   output logic [NUM_REGS-1:0]        set_mask
);

   logic                long_op, store_op, mark_en;
   logic [IDX_W-1:0]    mark_idx;
   logic [NUM_REGS-1:0] raw_mask;

   always_comb begin
      long_op  = sb_pkg::is_long_class(cls);
      store_op = sb_pkg::is_store_class(cls);
      mark_idx = store_op ? src_b : dst;
      mark_en  = grant & long_op & (store_op ? src_b_used : dst_used);
      raw_mask = '0;
      if (mark_en) raw_mask[mark_idx] = 1'b1;
   end

   if (R0_HARDWIRED) begin : g_r0_fixed
      localparam logic [NUM_REGS-1:0] KEEP = {{(NUM_REGS-1){1'b1}}, 1'b0};
      assign set_mask = raw_mask & KEEP;
   end else begin : g_r0_plain
      assign set_mask = raw_mask;
   end

endmodule

// File: rtl/sb_busy_array.sv
module sb_busy_array #(
   parameter int NUM_REGS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] set_mask,
   input  logic [NUM_REGS-1:0] clr_mask,
   output logic [NUM_REGS-1:0] busy
);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)           busy[r] <= 1'b0;
         else if (set_mask[r]) busy[r] <= 1'b1;
         else if (clr_mask[r]) busy[r] <= 1'b0;
      end
   end

endmodule

// File: rtl/sb_interlock.sv
module sb_interlock #(
   parameter int NUM_REGS     = 32,
   parameter int NUM_CPL      = 2,
   parameter bit R0_HARDWIRED = 1'b1,
   localparam int IDX_W       = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [sb_pkg::CLASS_W-1:0] in_class,
   input  logic [IDX_W-1:0]           in_src_a,
   input  logic                       in_src_a_used,
   input  logic [IDX_W-1:0]           in_src_b,
   input  logic                       in_src_b_used,
   input  logic [IDX_W-1:0]           in_dst,
   input  logic                       in_dst_used,
   input  logic [NUM_CPL-1:0]         cpl_valid,
   input  logic [NUM_CPL*IDX_W-1:0]   cpl_idx,
   output logic                       issue_grant,
   output logic                       issue_stall,
   output logic [NUM_REGS-1:0]        busy_vec
);

   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("sb_interlock: NUM_REGS must be a power of two of at least 2");
   end
   if (NUM_CPL < 1) begin : g_bad_cpl
      $error("sb_interlock: NUM_CPL must be at least 1");
   end

   logic [NUM_REGS-1:0] clr_mask, set_mask, eff_busy;
   logic                dst_check;

   sb_cpl_decode #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_cpl (
      .cpl_valid (cpl_valid),
      .cpl_idx   (cpl_idx),
      .clr_mask  (clr_mask)
   );

   // Completions in this cycle already release waiting instructions.
   assign eff_busy  = busy_vec & ~clr_mask;
   assign dst_check = in_dst_used & ~sb_pkg::is_store_class(in_class);

   sb_hazard #(.NUM_REGS(NUM_REGS)) u_haz (
      .eff_busy   (eff_busy),
      .in_valid   (in_valid),
      .src_a      (in_src_a),
      .src_a_used (in_src_a_used),
      .src_b      (in_src_b),
      .src_b_used (in_src_b_used),
      .dst        (in_dst),
      .dst_check  (dst_check),
      .grant      (issue_grant),
      .stall      (issue_stall)
   );

   sb_mark_select #(.NUM_REGS(NUM_REGS), .R0_HARDWIRED(R0_HARDWIRED)) u_mark (
      .grant      (issue_grant),
      .cls        (in_class),
      .src_b      (in_src_b),
      .src_b_used (in_src_b_used),
      .dst        (in_dst),
      .dst_used   (in_dst_used),
      .set_mask   (set_mask)
   );

   sb_busy_array #(.NUM_REGS(NUM_REGS)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .busy     (busy_vec)
   );

endmodule

// File: rtl/sb_interlock_chk.sv
module sb_interlock_chk #(
   parameter int NUM_REGS = 32,
   parameter int NUM_CPL  = 2,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic [sb_pkg::CLASS_W-1:0] in_class,
   input logic [IDX_W-1:0]           in_src_a,
   input logic                       in_src_a_used,
   input logic [IDX_W-1:0]           in_src_b,
   input logic                       in_src_b_used,
   input logic [IDX_W-1:0]           in_dst,
   input logic                       in_dst_used,
   input logic [NUM_CPL-1:0]         cpl_valid,
   input logic                       issue_grant,
   input logic                       issue_stall,
   input logic [NUM_REGS-1:0]        busy_vec
);

   logic quiet_cpl, long_cls, store_cls;
   assign quiet_cpl = (cpl_valid == '0);
   assign long_cls  = (in_class inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5});
   assign store_cls = (in_class == 3'd2);

   // R2
   grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_grant |-> in_valid);

   // R2
   grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_grant && issue_stall));

   // R9
   r0_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_vec[0]);

   // R3
   long_marks_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_grant && long_cls && !store_cls && in_dst_used && in_dst != '0)
      |=> busy_vec[$past(in_dst)]);

   // R4
   store_marks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_grant && store_cls && in_src_b_used && in_src_b != '0)
      |=> busy_vec[$past(in_src_b)]);

   // R5
   no_mark_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(issue_grant && long_cls) && quiet_cpl) |=> $stable(busy_vec));

   // R10
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_cpl |=> (($past(busy_vec) & ~busy_vec) == '0));

   // R6
   src_busy_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && quiet_cpl && in_src_a_used && busy_vec[in_src_a]) |-> issue_stall);

   // R7
   dst_busy_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && quiet_cpl && !store_cls && in_dst_used && busy_vec[in_dst]) |-> issue_stall);

endmodule

bind sb_interlock sb_interlock_chk #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_class      (in_class),
   .in_src_a      (in_src_a),
   .in_src_a_used (in_src_a_used),
   .in_src_b      (in_src_b),
   .in_src_b_used (in_src_b_used),
   .in_dst        (in_dst),
   .in_dst_used   (in_dst_used),
   .cpl_valid     (cpl_valid),
   .issue_grant   (issue_grant),
   .issue_stall   (issue_stall),
   .busy_vec      (busy_vec)
);

// File: tb/sb_interlock_tb.sv
module sb_interlock_tb;

   localparam logic [2:0] C_ALU = 3'd0, C_LD = 3'd1, C_ST = 3'd2, C_MUL = 3'd3,
                          C_DIV = 3'd4, C_FP = 3'd5, C_R6 = 3'd6, C_R7 = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_class = '0;
   logic [4:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic        in_src_a_used = 1'b0, in_src_b_used = 1'b0, in_dst_used = 1'b0;
   logic [1:0]  cpl_valid = '0;
   logic [9:0]  cpl_idx = '0;
   logic        issue_grant, issue_stall;
   logic [31:0] busy_vec;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [31:0] exp_busy;

   always #5 clk = ~clk;

   sb_interlock u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_src_a(in_src_a), .in_src_a_used(in_src_a_used),
      .in_src_b(in_src_b), .in_src_b_used(in_src_b_used),
      .in_dst(in_dst), .in_dst_used(in_dst_used),
      .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
      .issue_grant(issue_grant), .issue_stall(issue_stall), .busy_vec(busy_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic [2:0] c,
                        input logic [4:0] a, input logic au,
                        input logic [4:0] b, input logic bu,
                        input logic [4:0] d, input logic du);
      in_valid = v; in_class = c;
      in_src_a = a; in_src_a_used = au;
      in_src_b = b; in_src_b_used = bu;
      in_dst = d;   in_dst_used = du;
      #1;
   endtask

   task automatic set_cpl(input logic v0, input logic [4:0] i0,
                          input logic v1, input logic [4:0] i1);
      cpl_valid = {v1, v0};
      cpl_idx   = {i1, i0};
   endtask

   // Move to the next falling edge, return inputs to idle.
   task automatic advance();
      @(negedge clk);
      in_valid = 1'b0; in_src_a_used = 1'b0; in_src_b_used = 1'b0; in_dst_used = 1'b0;
      cpl_valid = '0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 busy after reset", busy_vec, 32'h0);
      chk("R1 grant idle", {31'b0, issue_grant}, 32'h0);
      chk("R1 stall idle", {31'b0, issue_stall}, 32'h0);
   endtask

   task automatic t_long_ops();
      apply(1, C_LD, 0, 0, 0, 0, 5, 1);
      chk("R3 load granted", {31'b0, issue_grant}, 32'h1);
      advance();
      apply(1, C_MUL, 1, 1, 2, 1, 7, 1);  advance();
      apply(1, C_DIV, 1, 1, 2, 1, 9, 1);  advance();
      apply(1, C_FP, 3, 1, 4, 1, 11, 1);  advance();
      exp_busy = (32'h1 << 5) | (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 11);
      chk("R3 long-latency marks", busy_vec, exp_busy);
   endtask

   task automatic t_store();
      apply(1, C_ST, 3, 1, 12, 1, 20, 1);
      chk("R4 store granted", {31'b0, issue_grant}, 32'h1);
      advance();
      exp_busy = exp_busy | (32'h1 << 12);
      chk("R4 store marks data reg", busy_vec, exp_busy);
   endtask

   task automatic t_short();
      apply(1, C_ALU, 1, 1, 2, 1, 14, 1);
      chk("R5 alu granted", {31'b0, issue_grant}, 32'h1);
      advance();
      apply(1, C_R6, 1, 1, 2, 1, 15, 1);  advance();
      apply(1, C_R7, 1, 1, 2, 1, 16, 1);  advance();
      chk("R5 single-cycle classes leave flags", busy_vec, exp_busy);
   endtask

   task automatic t_raw_wait();
      for (int k = 0; k < 4; k++) begin
         apply(1, C_ALU, 5, 1, 0, 0, 17, 1);
         chk("R6 stall on busy source", {30'b0, issue_stall, issue_grant}, 32'h2);
         advance();
         chk("R10 flag held while waiting", busy_vec, exp_busy);
      end
      set_cpl(1, 5, 0, 0);
      apply(1, C_ALU, 5, 1, 0, 0, 17, 1);
      chk("R8 same-cycle release", {30'b0, issue_stall, issue_grant}, 32'h1);
      advance();
      exp_busy = exp_busy & ~(32'h1 << 5);
      chk("R8 flag cleared", busy_vec, exp_busy);
   endtask

   task automatic t_waw();
      apply(1, C_ALU, 0, 0, 0, 0, 7, 1);
      chk("R7 stall on busy dest (alu)", {31'b0, issue_stall}, 32'h1);
      advance();
      apply(1, C_LD, 2, 1, 0, 0, 9, 1);
      chk("R7 stall on busy dest (load)", {31'b0, issue_stall}, 32'h1);
      advance();
      chk("R6 stalled ops change nothing", busy_vec, exp_busy);
   endtask

   task automatic t_r0();
      apply(1, C_LD, 1, 1, 0, 0, 0, 1);
      chk("R9 load to r0 granted", {31'b0, issue_grant}, 32'h1);
      advance();
      chk("R9 r0 never flagged", busy_vec, exp_busy);
      apply(1, C_ALU, 0, 1, 0, 1, 0, 1);
      chk("R9 r0 operands never stall", {31'b0, issue_grant}, 32'h1);
      advance();
   endtask

   task automatic t_multi();
      set_cpl(1, 7, 1, 9);
      apply(0, C_ALU, 0, 0, 0, 0, 0, 0);
      advance();
      exp_busy = exp_busy & ~((32'h1 << 7) | (32'h1 << 9));
      chk("R11 two ports clear two flags", busy_vec, exp_busy);
      set_cpl(1, 30, 0, 0);
      apply(0, C_ALU, 0, 0, 0, 0, 0, 0);
      advance();
      chk("R11 stray completion ignored", busy_vec, exp_busy);
   endtask

   task automatic t_novalid();
      apply(0, C_LD, 0, 0, 0, 0, 21, 1);
      chk("R2 no grant without valid", {30'b0, issue_stall, issue_grant}, 32'h0);
      advance();
      chk("R2 invalid op leaves flags", busy_vec, exp_busy);
   endtask

   task automatic t_set_wins();
      set_cpl(0, 0, 1, 11);
      apply(1, C_LD, 2, 1, 0, 0, 11, 1);
      chk("R8 release and reissue granted", {31'b0, issue_grant}, 32'h1);
      advance();
      chk("R8 re-marked flag stays set", busy_vec, exp_busy);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      exp_busy = '0;
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      advance();
      t_reset();
      t_long_ops();
      t_store();
      t_short();
      t_raw_wait();
      t_waw();
      t_r0();
      t_multi();
      t_novalid();
      t_set_wins();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule